// File: doc/BRIEF.md
# Pulse-width time code symbol generator

This block plays a 100-symbol time frame out as a serial, pulse-width-coded DC time code on a single output pin. It runs on the system clock and moves forward only on cycles where a 1 kHz tick enable is high. Every symbol lasts ten ticks and begins with a rising edge. The time spent high before the fall encodes the symbol: a short pulse for a binary zero, a half-width pulse for a binary one, and a long pulse for a position marker.

An upstream agent writes a whole frame of two-bit symbol codes through a parallel port with a one-cycle load strobe. The frame lands in a holding register and becomes active only at a frame boundary, so the frame on the wire is never a mix of two frames. While no new frame arrives, the active frame repeats. A level output tells the agent when the holding register is free. A one-cycle pulse marks the start of each frame.

Top module: `pwtc_gen`

## Requirements
- R1: While synchronous reset is applied, and in the cycle that follows it, `tc_out` is 0, `frame_start` is 0 and `frame_req` is 1.
- R2: Until the first frame has been loaded, `tc_out` stays 0 on every tick.
- R3: `tc_out` changes only in the cycle after a tick. Each symbol spans exactly 10 ticks, and the new level appears in the cycle after the tick that emits it.
- R4: Symbol code 2'b00 (binary zero) gives 2 high ticks and then 8 low ticks.
- R5: Symbol code 2'b01 (binary one) gives 5 high ticks and then 5 low ticks.
- R6: Symbol code 2'b10 (position marker) gives 8 high ticks and then 2 low ticks.
- R7: Symbol code 2'b11 produces the same waveform as code 2'b00.
- R8: Symbol i is taken from `frame_in[2i+1:2i]`, and symbols go out from 0 to 99. After symbol 99 the frame restarts at symbol 0, repeating the same frame unless a new one is waiting.
- R9: A load captures `frame_in` into a holding register and drives `frame_req` low from the next cycle. The waiting frame becomes active after the last tick of the current frame, or at once if no frame is playing. `frame_req` returns to 1 when the waiting frame becomes active, and a load never changes the frame already playing.
- R10: `frame_start` is high for exactly one cycle: the cycle after the tick that emits tick 0 of symbol 0. It is low in every other cycle.
- R11: Every symbol starts with a rising edge, so `tc_out` is 1 after the first tick of each symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | 1 kHz timebase enable, one clock cycle wide |
| load | input | 1 | One-cycle strobe that captures `frame_in` |
| frame_in | input | 200 | 100 symbol codes, symbol i at bits [2i+1:2i] |
| frame_req | output | 1 | High when the holding register is free for a new frame |
| tc_out | output | 1 | Serial pulse-width time code level |
| frame_start | output | 1 | One-cycle pulse at the start of symbol 0 |

## Verification
The assertions assume that `tick` is high for one clock cycle at a time and that frames have more than one tick per symbol. They also assume that `load` is a single-cycle strobe with `frame_in` valid in that cycle. The stimulus holds `tick` high for one cycle and then low for three, and it applies loads only between ticks, including one in the middle of a playing frame. The expected waveform is built tick by tick from the symbol codes. The monitor also checks that the output holds its level between ticks and that no frame-start pulse appears outside a frame origin.

// File: rtl/pwtc_pkg.sv
package pwtc_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        SYM_ZERO = 2'b00,
        SYM_ONE  = 2'b01,
        SYM_MARK = 2'b10,
        SYM_RSVD = 2'b11
    } sym_code_e;

    // High-time in ticks for a symbol code; the reserved code shapes as zero.
    function automatic int unsigned high_ticks(input logic [CODE_W-1:0] code,
                                               input int unsigned w_zero,
                                               input int unsigned w_one,
                                               input int unsigned w_mark);
        int unsigned w;
        case (sym_code_e'(code))
            SYM_ONE:  w = w_one;
            SYM_MARK: w = w_mark;
            default:  w = w_zero;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pwtc_frame_store.sv
module pwtc_frame_store
    import pwtc_pkg::*;
#(
    parameter int SYMS  = 100,
    parameter int SYM_W = $clog2(SYMS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [SYMS*CODE_W-1:0] frame_in,
    input  logic                   take,
    input  logic [SYM_W-1:0]       sym_idx,
    output logic                   pending,
    output logic [CODE_W-1:0]      cur_code
);

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t [SYMS-1:0] shadow;
        code_t [SYMS-1:0] active;
        logic             pending;
    } store_t;

    localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(SYMS - 1);

    store_t st_d, st_q;
    code_t [SYMS-1:0] in_codes;

    // Unpack the flat port into per-symbol codes.
    for (genvar g = 0; g < SYMS; g++) begin : g_unpack
        assign in_codes[g] = frame_in[g*CODE_W +: CODE_W];
    end

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.active  = st_q.shadow;
            st_d.pending = 1'b0;
        end
        // A load in the same cycle as a copy is kept for the next boundary.
        if (load) begin
            st_d.shadow  = in_codes;
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pending  = st_q.pending;
    assign cur_code = (sym_idx <= LAST_SYM) ? st_q.active[sym_idx] : code_t'(0);

    a_r9_load_sets_pending: assert property (@(posedge clk) disable iff (rst)
        load |=> pending);

    a_r9_take_clears: assert property (@(posedge clk) disable iff (rst)
        (take && !load) |=> !pending);

endmodule

// File: rtl/pwtc_sequencer.sv
module pwtc_sequencer #(
    parameter int SYMS  = 100,
    parameter int TICKS = 10,
    parameter int SYM_W = $clog2(SYMS),
    parameter int TK_W  = $clog2(TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             pending,
    output logic             take,
    output logic             emit,
    output logic             origin,
    output logic [SYM_W-1:0] sym_idx,
    output logic [TK_W-1:0]  tk_idx
);

    localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(SYMS - 1);
    localparam logic [TK_W-1:0]  LAST_TK  = TK_W'(TICKS - 1);

    typedef struct packed {
        logic             running;
        logic [SYM_W-1:0] sym;
        logic [TK_W-1:0]  tk;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        emit = st_q.running && tick;
        if (!st_q.running) begin
            if (pending) begin
                take         = 1'b1;
                st_d.running = 1'b1;
                st_d.sym     = '0;
                st_d.tk      = '0;
            end
        end else if (tick) begin
            if (st_q.tk == LAST_TK) begin
                st_d.tk = '0;
                if (st_q.sym == LAST_SYM) begin
                    st_d.sym = '0;
                    take     = pending;
                end else begin
                    st_d.sym = st_q.sym + 1'b1;
                end
            end else begin
                st_d.tk = st_q.tk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sym_idx = st_q.sym;
    assign tk_idx  = st_q.tk;
    assign origin  = (st_q.sym == '0) && (st_q.tk == '0);

    a_r3_tick_in_range: assert property (@(posedge clk) disable iff (rst)
        tk_idx <= LAST_TK);

    a_r8_sym_in_range: assert property (@(posedge clk) disable iff (rst)
        sym_idx <= LAST_SYM);

    a_r3_no_move_without_tick: assert property (@(posedge clk) disable iff (rst)
        (emit == 1'b0 && !take) |=> $stable(tk_idx) && $stable(sym_idx));

    a_r8_wrap_to_origin: assert property (@(posedge clk) disable iff (rst)
        (emit && sym_idx == LAST_SYM && tk_idx == LAST_TK) |=> origin);

endmodule

// File: rtl/pwtc_shaper.sv
module pwtc_shaper
    import pwtc_pkg::*;
#(
    parameter int TICKS  = 10,
    parameter int TK_W   = $clog2(TICKS),
    parameter int W_ZERO = 2,
    parameter int W_ONE  = 5,
    parameter int W_MARK = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              emit,
    input  logic              origin,
    input  logic [CODE_W-1:0] code,
    input  logic [TK_W-1:0]   tk_idx,
    output logic              tc_out,
    output logic              frame_start
);

    typedef struct packed {
        logic level;
        logic start;
    } shape_t;

    shape_t st_d, st_q;
    int unsigned hi_len;

    always_comb begin
        hi_len = high_ticks(code, W_ZERO, W_ONE, W_MARK);
        st_d   = st_q;
        st_d.start = 1'b0;
        if (emit) begin
            st_d.level = (32'(tk_idx) < hi_len);
            st_d.start = origin;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tc_out      = st_q.level;
    assign frame_start = st_q.start;

    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !emit |=> $stable(tc_out));

    a_r11_symbol_rises: assert property (@(posedge clk) disable iff (rst)
        (emit && tk_idx == '0) |=> tc_out);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

endmodule

// File: rtl/pwtc_gen.sv
module pwtc_gen
    import pwtc_pkg::*;
#(
    parameter int SYMS   = 100,
    parameter int TICKS  = 10,
    parameter int W_ZERO = 2,
    parameter int W_ONE  = 5,
    parameter int W_MARK = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   load,
    input  logic [SYMS*CODE_W-1:0] frame_in,
    output logic                   frame_req,
    output logic                   tc_out,
    output logic                   frame_start
);

    localparam int SYM_W = $clog2(SYMS);
    localparam int TK_W  = $clog2(TICKS);

    logic              pending;
    logic              take;
    logic              emit;
    logic              origin;
    logic [SYM_W-1:0]  sym_idx;
    logic [TK_W-1:0]   tk_idx;
    logic [CODE_W-1:0] cur_code;

    pwtc_frame_store #(
        .SYMS  (SYMS),
        .SYM_W (SYM_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .frame_in (frame_in),
        .take     (take),
        .sym_idx  (sym_idx),
        .pending  (pending),
        .cur_code (cur_code)
    );

    pwtc_sequencer #(
        .SYMS  (SYMS),
        .TICKS (TICKS),
        .SYM_W (SYM_W),
        .TK_W  (TK_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .pending (pending),
        .take    (take),
        .emit    (emit),
        .origin  (origin),
        .sym_idx (sym_idx),
        .tk_idx  (tk_idx)
    );

    pwtc_shaper #(
        .TICKS  (TICKS),
        .TK_W   (TK_W),
        .W_ZERO (W_ZERO),
        .W_ONE  (W_ONE),
        .W_MARK (W_MARK)
    ) u_shape (
        .clk         (clk),
        .rst         (rst),
        .emit        (emit),
        .origin      (origin),
        .code        (cur_code),
        .tk_idx      (tk_idx),
        .tc_out      (tc_out),
        .frame_start (frame_start)
    );

    assign frame_req = !pending;

    a_r10_start_on_high: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> tc_out);

    a_r9_req_low_after_load: assert property (@(posedge clk) disable iff (rst)
        load |=> !frame_req);

endmodule

// File: tb/pwtc_gen_tb.sv
module pwtc_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SYMS  = 100;
    localparam int TICKS = 10;
    localparam int FW    = SYMS * 2;

    typedef struct {
        logic  lvl;
        logic  st;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic load = 1'b0;
    logic [FW-1:0] frame_in = '0;
    logic frame_req, tc_out, frame_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_en = 1'b0;
    logic tick_seen = 1'b0;
    logic last_out = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwtc_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .load        (load),
        .frame_in    (frame_in),
        .frame_req   (frame_req),
        .tc_out      (tc_out),
        .frame_start (frame_start)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] code_of(input logic [FW-1:0] f, input int s);
        return f[2*s +: 2];
    endfunction

    function automatic int width_of(input logic [1:0] c);
        case (c)
            2'b01:   return 5;
            2'b10:   return 8;
            default: return 2;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] c);
        case (c)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [FW-1:0] mk_frame(input int kind);
        logic [FW-1:0] f;
        f = '0;
        for (int i = 0; i < SYMS; i++) begin
            logic [1:0] c;
            if (i == 0 || i % 10 == 9) c = 2'b10;
            else if (kind == 0) begin
                case (i % 4)
                    0: c = 2'b00;
                    1: c = 2'b01;
                    2: c = 2'b11;
                    default: c = 2'b01;
                endcase
            end else begin
                case ((i * 7) % 3)
                    0: c = 2'b01;
                    1: c = 2'b00;
                    default: c = 2'b10;
                endcase
            end
            f[2*i +: 2] = c;
        end
        return f;
    endfunction

    // Driver: expected items for symbols [s_from, s_to] of a frame (R8 order).
    task automatic push_syms(input logic [FW-1:0] f, input int s_from, input int s_to);
        for (int s = s_from; s <= s_to; s++) begin
            for (int k = 0; k < TICKS; k++) begin
                exp_t e;
                e.lvl = (k < width_of(code_of(f, s)));
                e.st  = (s == 0 && k == 0);
                e.tag = (k == 0) ? "R11" : tag_of(code_of(f, s));
                exp_q.push_back(e);
            end
        end
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic load_frame(input logic [FW-1:0] f);
        @(negedge clk);
        frame_in = f;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check("R9 req low after load", frame_req, 1'b0);
    endtask

    always @(posedge clk) tick_seen <= tick;

    // Monitor: pop one expected item per tick, check hold between ticks.
    always @(negedge clk) begin
        if (mon_en) begin
            if (tick_seen) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R8: actual=tick expected=no tick (queue empty)");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " level"}, tc_out, e.lvl);
                    check("R10 frame_start at tick", frame_start, e.st);
                end
            end else begin
                check("R3 hold between ticks", tc_out, last_out);
                check("R10 no pulse off tick", frame_start, 1'b0);
            end
            last_out = tc_out;
        end
    end

    initial begin
        logic [FW-1:0] fa, fb;
        fa = mk_frame(0);
        fb = mk_frame(1);

        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 tc_out in reset", tc_out, 1'b0);
        check("R1 frame_req in reset", frame_req, 1'b1);
        check("R1 frame_start in reset", frame_start, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 tc_out after reset", tc_out, 1'b0);
        check("R1 frame_req after reset", frame_req, 1'b1);
        last_out = tc_out;
        mon_en = 1'b1;

        // R2: ticks with no frame loaded keep the output low.
        for (int i = 0; i < 5; i++) begin
            exp_t e;
            e.lvl = 1'b0;
            e.st  = 1'b0;
            e.tag = "R2";
            exp_q.push_back(e);
        end
        run_ticks(5);

        // Idle load: frame becomes active at once.
        load_frame(fa);
        @(negedge clk);
        check("R9 req high after idle copy", frame_req, 1'b1);

        // First half of frame A, then load B mid-frame.
        push_syms(fa, 0, 49);
        run_ticks(500);
        load_frame(fb);
        push_syms(fa, 50, 99);   // R9: frame A continues unchanged
        run_ticks(499);
        check("R9 req low while waiting", frame_req, 1'b0);
        run_ticks(1);
        check("R9 req high after boundary copy", frame_req, 1'b1);

        // Frame B, then B again (R8 repeat with no new load).
        push_syms(fb, 0, 99);
        run_ticks(1000);
        push_syms(fb, 0, 99);
        run_ticks(1000);
        repeat (4) @(negedge clk);
        check("R8 queue drained", exp_q.size() == 0, 1'b1);

        mon_en = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule